// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side, and a table of chooser counters decides which one supplies the output. The global component is a table of two-bit saturating counters indexed by a shift register that holds the outcomes of the most recent resolved branches. The local component works in two levels. A per-branch history table, indexed by low PC bits, gives a pattern of that branch's own recent outcomes. That pattern then indexes a table of three-bit saturating counters.

A fetch stage presents a PC and reads the prediction combinationally in the same cycle. When a branch resolves, its PC and actual outcome arrive on the resolve port. On that clock edge every affected table entry and both history registers are trained. The table sizes are parameters. The widths that give roughly 29 Kbits of storage are a global history of 12, a local-history index of 10 and a local history of 10. The defaults are smaller so that elaboration stays light.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every counter holds its weakly-not-taken value (2-bit: 1, 3-bit: 3) and all histories are zero, so predTaken is 0 for every fetchPc.
- R2: The global prediction is the most significant bit of a 2-bit saturating counter, selected by the global history register.
- R3: Each resolve shifts its outcome into bit 0 of the global history, so bit i is 1 when the i-th most recent resolved branch was taken. The older bits move up by one and the oldest is dropped.
- R4: The local history entry is selected by PC bits [LIDX_W+1:2], so PCs that share these bits share an entry. Each resolve shifts its outcome into bit 0 of the entry selected by resPc.
- R5: The local prediction is the most significant bit of a 3-bit saturating counter, selected by the local history entry of the PC.
- R6: The chooser counter, selected by the global history, is trained only when the two component predictions for the resolving branch differ. It is incremented when the global prediction was correct and decremented when the local prediction was correct.
- R7: predTaken is the global prediction when the chooser counter's most significant bit is 1, and the local prediction otherwise.
- R8: On a resolve, the selected global and local counters count up when the branch was taken and down when it was not, and they saturate at 0 and at their maximum.
- R9: While resValid is 0, no table and no history changes, whatever resPc and resTaken carry.
- R10: The prediction is combinational from fetchPc and the state before the clock edge. A resolve in the same cycle affects predictions only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | PC_W | PC to predict |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| resValid | input | 1 | A branch resolves this cycle |
| resPc | input | PC_W | PC of the resolving branch |
| resTaken | input | 1 | Actual outcome of the resolving branch |

## Verification
The bound assertions check on every cycle the shift of the global history on a resolve and its stillness without one. They also check that the chooser is never trained while the components agree, that it never steps both ways at once, and that the prediction is not-taken right after reset. Only the bench's scenarios can show how the counters saturate, how PCs alias in the local history table and how the chooser migrates between components. The bench shows these by comparing predTaken against a behavioural model over interleaved branch patterns, long taken runs, idle cycles and a mid-run reset.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef struct packed {
    logic wrEn;   // train components and histories
    logic dir;    // outcome to train with
    logic chInc;  // move chooser toward global
    logic chDec;  // move chooser toward local
  } strobe_t;
endpackage

// File: rtl/tp_satstep.sv
module tp_satstep #(
  parameter int W = 2
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] MINV = '0;

  always_comb begin
    if (up) nxt = (cur == MAXV) ? cur : cur + 1'b1;
    else    nxt = (cur == MINV) ? cur : cur - 1'b1;
  end
endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl (
  input  logic             resValid,
  input  logic             resTaken,
  input  logic             resGlobal,
  input  logic             resLocal,
  output tp_pkg::strobe_t  strobes
);
  logic disagree;

  always_comb begin
    disagree      = resGlobal ^ resLocal;
    strobes.wrEn  = resValid;
    strobes.dir   = resTaken;
    strobes.chInc = resValid && disagree && (resGlobal == resTaken);
    strobes.chDec = resValid && disagree && (resLocal == resTaken);
  end
endmodule

// File: rtl/tp_datapath.sv
module tp_datapath #(
  parameter int PC_W   = 32,
  parameter int GH_W   = 8,
  parameter int LIDX_W = 6,
  parameter int LH_W   = 8,
  parameter int GC_W   = 2,
  parameter int LC_W   = 3,
  parameter int CC_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [PC_W-1:0]  resPc,
  input  tp_pkg::strobe_t  strobes,
  output logic             predTaken,
  output logic             resGlobal,
  output logic             resLocal,
  output logic [GH_W-1:0]  ghist
);
  localparam int G_N   = 1 << GH_W;
  localparam int LHT_N = 1 << LIDX_W;
  localparam int LP_N  = 1 << LH_W;
  localparam logic [GC_W-1:0] G_WNT = {1'b0, {(GC_W-1){1'b1}}};
  localparam logic [LC_W-1:0] L_WNT = {1'b0, {(LC_W-1){1'b1}}};
  localparam logic [CC_W-1:0] C_WNT = {1'b0, {(CC_W-1){1'b1}}};

  logic [GC_W-1:0] globTab    [G_N];
  logic [CC_W-1:0] chooserTab [G_N];
  logic [LH_W-1:0] lhtTab     [LHT_N];
  logic [LC_W-1:0] locTab     [LP_N];

  // fetch-side lookup
  logic [LIDX_W-1:0] fIdx;
  logic [LH_W-1:0]   fHist;
  logic              fGlob, fLoc, fSel;

  always_comb begin
    fIdx      = fetchPc[LIDX_W+1:2];
    fHist     = lhtTab[fIdx];
    fGlob     = globTab[ghist][GC_W-1];
    fLoc      = locTab[fHist][LC_W-1];
    fSel      = chooserTab[ghist][CC_W-1];
    predTaken = fSel ? fGlob : fLoc;
  end

  // resolve-side lookup
  logic [LIDX_W-1:0] rIdx;
  logic [LH_W-1:0]   rHist;
  logic [GC_W-1:0]   rGlobCnt, gNext;
  logic [LC_W-1:0]   rLocCnt, lNext;
  logic [CC_W-1:0]   rChCnt, cNext;

  always_comb begin
    rIdx      = resPc[LIDX_W+1:2];
    rHist     = lhtTab[rIdx];
    rGlobCnt  = globTab[ghist];
    rLocCnt   = locTab[rHist];
    rChCnt    = chooserTab[ghist];
    resGlobal = rGlobCnt[GC_W-1];
    resLocal  = rLocCnt[LC_W-1];
  end

  tp_satstep #(.W(GC_W)) uGStep (.cur(rGlobCnt), .up(strobes.dir),   .nxt(gNext));
  tp_satstep #(.W(LC_W)) uLStep (.cur(rLocCnt),  .up(strobes.dir),   .nxt(lNext));
  tp_satstep #(.W(CC_W)) uCStep (.cur(rChCnt),   .up(strobes.chInc), .nxt(cNext));

  always_ff @(posedge clk) begin
    if (!rstN) ghist <= '0;
    else if (strobes.wrEn) ghist <= {ghist[GH_W-2:0], strobes.dir};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < G_N; i++) globTab[i] <= G_WNT;
    end else if (strobes.wrEn) begin
      globTab[ghist] <= gNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < G_N; i++) chooserTab[i] <= C_WNT;
    end else if (strobes.chInc || strobes.chDec) begin
      chooserTab[ghist] <= cNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LHT_N; i++) lhtTab[i] <= '0;
    end else if (strobes.wrEn) begin
      lhtTab[rIdx] <= {rHist[LH_W-2:0], strobes.dir};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LP_N; i++) locTab[i] <= L_WNT;
    end else if (strobes.wrEn) begin
      locTab[rHist] <= lNext;
    end
  end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
  parameter int PC_W   = 32,
  parameter int GH_W   = 8,
  parameter int LIDX_W = 6,
  parameter int LH_W   = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predTaken,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken
);
  tp_pkg::strobe_t strobes;
  logic            resGlobal, resLocal;
  logic [GH_W-1:0] ghist;

  tp_ctrl uCtrl (
    .resValid (resValid),
    .resTaken (resTaken),
    .resGlobal(resGlobal),
    .resLocal (resLocal),
    .strobes  (strobes)
  );

  tp_datapath #(
    .PC_W(PC_W), .GH_W(GH_W), .LIDX_W(LIDX_W), .LH_W(LH_W),
    .GC_W(2), .LC_W(3), .CC_W(2)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .fetchPc  (fetchPc),
    .resPc    (resPc),
    .strobes  (strobes),
    .predTaken(predTaken),
    .resGlobal(resGlobal),
    .resLocal (resLocal),
    .ghist    (ghist)
  );
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int GH_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            resValid,
  input logic            resTaken,
  input logic            predTaken,
  input logic [GH_W-1:0] ghist,
  input logic            resGlobal,
  input logic            resLocal,
  input tp_pkg::strobe_t strobes
);
  AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !predTaken) else $error("reset prediction"); // R1

  AST_GHIST_NEWEST: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> ghist[0] == $past(resTaken)) else $error("ghist bit0"); // R3

  AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> ghist[GH_W-1:1] == $past(ghist[GH_W-2:0])) else $error("ghist shift"); // R3

  AST_GHIST_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |=> $stable(ghist)) else $error("ghist idle"); // R9

  AST_CHOOSER_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.chInc || strobes.chDec) |-> (resValid && (resGlobal != resLocal))) else $error("chooser trained"); // R6

  AST_CHOOSER_ONEWAY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.chInc, strobes.chDec})) else $error("chooser both"); // R6
endmodule

bind tourney_predictor tp_checker #(.GH_W(GH_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .resValid (resValid),
  .resTaken (resTaken),
  .predTaken(predTaken),
  .ghist    (ghist),
  .resGlobal(resGlobal),
  .resLocal (resLocal),
  .strobes  (strobes)
);

// File: tb/tourney_predictor_test.sv
module tourney_predictor_test;
  localparam int CLK_PERIOD = 10;
  localparam int GH = 8;
  localparam int LI = 6;
  localparam int LH = 8;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        predTaken;
  logic        resValid = 1'b0;
  logic [31:0] resPc = '0;
  logic        resTaken = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  tourney_predictor uut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predTaken(predTaken),
    .resValid(resValid), .resPc(resPc), .resTaken(resTaken)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model built from the requirements
  int mGh;
  int mGlob [1<<GH];
  int mCh   [1<<GH];
  int mLht  [1<<LI];
  int mLoc  [1<<LH];

  function automatic int lidx(logic [31:0] pc);
    return int'((pc >> 2) & ((1 << LI) - 1));
  endfunction

  task automatic modelReset();
    mGh = 0;
    for (int i = 0; i < (1<<GH); i++) begin mGlob[i] = 1; mCh[i] = 1; end
    for (int i = 0; i < (1<<LI); i++) mLht[i] = 0;
    for (int i = 0; i < (1<<LH); i++) mLoc[i] = 3;
  endtask

  function automatic bit modelPred(logic [31:0] pc);
    bit gp, lp;
    gp = mGlob[mGh] >= 2;
    lp = mLoc[mLht[lidx(pc)]] >= 4;
    return (mCh[mGh] >= 2) ? gp : lp;
  endfunction

  task automatic modelTrain(logic [31:0] pc, bit t);
    bit gp, lp;
    int h;
    h  = mLht[lidx(pc)];
    gp = mGlob[mGh] >= 2;
    lp = mLoc[h] >= 4;
    if (gp != lp) begin
      if (gp == t) mCh[mGh] = (mCh[mGh] < 3) ? mCh[mGh] + 1 : 3;
      else         mCh[mGh] = (mCh[mGh] > 0) ? mCh[mGh] - 1 : 0;
    end
    if (t) begin
      mGlob[mGh] = (mGlob[mGh] < 3) ? mGlob[mGh] + 1 : 3;
      mLoc[h]    = (mLoc[h] < 7) ? mLoc[h] + 1 : 7;
    end else begin
      mGlob[mGh] = (mGlob[mGh] > 0) ? mGlob[mGh] - 1 : 0;
      mLoc[h]    = (mLoc[h] > 0) ? mLoc[h] - 1 : 0;
    end
    mLht[lidx(pc)] = ((h << 1) | int'(t)) & ((1 << LH) - 1);
    mGh = ((mGh << 1) | int'(t)) & ((1 << GH) - 1);
  endtask

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: predTaken=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // check prediction for pc, resolve it with outcome t in the same cycle (R10)
  task automatic stepResolve(logic [31:0] pc, bit t, string tag);
    @(negedge clk);
    fetchPc  = pc;
    resPc    = pc;
    resTaken = t;
    resValid = 1'b1;
    #1;
    check(predTaken, modelPred(pc), tag);
    @(posedge clk);
    modelTrain(pc, t);
    @(negedge clk);
    resValid = 1'b0;
  endtask

  task automatic peek(logic [31:0] pc, string tag);
    @(negedge clk);
    fetchPc = pc;
    #1;
    check(predTaken, modelPred(pc), tag);
  endtask

  localparam logic [31:0] PA = 32'h0000_1000; // local index 0
  localparam logic [31:0] PB = 32'h0000_1004; // local index 1
  localparam logic [31:0] PC = 32'h0000_20FC; // local index 63
  localparam logic [31:0] PD = 32'h0000_1100; // local index 0, aliases PA

  // bit 32: outcome, bits 31:0: PC
  localparam logic [32:0] VEC [24] = '{
    {1'b1, PA}, {1'b1, PB}, {1'b0, PC}, {1'b0, PD},
    {1'b1, PA}, {1'b0, PB}, {1'b0, PC}, {1'b0, PD},
    {1'b1, PA}, {1'b1, PB}, {1'b0, PC}, {1'b1, PD},
    {1'b1, PA}, {1'b0, PB}, {1'b0, PC}, {1'b0, PD},
    {1'b1, PA}, {1'b1, PB}, {1'b0, PC}, {1'b0, PD},
    {1'b1, PA}, {1'b0, PB}, {1'b0, PC}, {1'b1, PD}
  };

  initial begin : watchdog
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog: expired=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state predicts not-taken everywhere
    peek(PA, "R1 reset PA");
    peek(PB, "R1 reset PB");
    peek(PC, "R1 reset PC");

    // R2 R3 R4 R5 R6 R7 R8: interleaved patterns, aliasing PA/PD, chooser migration
    for (int r = 0; r < 6; r++) begin
      for (int v = 0; v < 24; v++) begin
        stepResolve(VEC[v][31:0], VEC[v][32], "R2 R3 R4 R5 R6 R7 table");
      end
    end

    // R9: resolve inputs toggling but resValid low must change nothing
    @(negedge clk);
    resPc = PB; resTaken = 1'b1; resValid = 1'b0;
    repeat (6) @(negedge clk);
    resTaken = 1'b0; resPc = PA;
    repeat (4) @(negedge clk);
    peek(PA, "R9 idle PA");
    peek(PB, "R9 idle PB");
    peek(PC, "R9 idle PC");
    peek(PD, "R9 idle PD");

    // R8: long taken run on one PC drives counters into saturation
    for (int k = 0; k < 30; k++) stepResolve(PC, 1'b1, "R8 saturate up");
    for (int k = 0; k < 12; k++) stepResolve(PC, 1'b0, "R8 saturate down");
    for (int k = 0; k < 12; k++) stepResolve(PB, k[0], "R6 R7 alternate");

    // R10: same-cycle resolve must not alter the prediction seen in that cycle
    stepResolve(PA, 1'b0, "R10 same cycle");
    peek(PA, "R10 next cycle");

    // R1: reset in the middle of activity
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    peek(PA, "R1 re-reset PA");
    peek(PB, "R1 re-reset PB");
    peek(PC, "R1 re-reset PC");
    peek(PD, "R1 re-reset PD");
    check(predTaken, 1'b0, "R1 re-reset literal");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule